// File: doc/BRIEF.md
# Multi-Channel Capacitive Scan Sequencer

This block is the digital controller of a seven-channel capacitive touch front end. Each channel delivers a free-running relaxation-oscillator signal whose frequency drops when a finger loads the electrode. The block measures one channel by counting the rising edges of that channel's oscillator inside a window timed by a slow reference clock. Both the oscillator inputs and the reference clock are asynchronous and pass through two-flop synchronizers before use.

Software programs a small register file and then sets a start bit. In single mode the lowest set bit of a 7-bit select field picks one channel and its count lands in a single-result register. In scan mode every channel enabled in a 7-bit mask is measured in ascending order and each count lands in its own 16-bit slot. The slots are packed two per 32-bit word, with the even channel in the low half. A result can optionally be compared against a per-channel threshold in a per-channel direction. A channel whose oscillator stays silent for too long is flagged as timed out and scored zero. Sticky flags, cleared by writing 1, drive one interrupt line.

The controller is a five-state machine. IDLE waits for the start bit and then loads the set of channels to visit (transition IDLE→PICK). PICK finishes when that set is empty (PICK→FINISH). Otherwise PICK takes the lowest remaining channel and clears the meter (PICK→MEAS). MEAS runs the meter until the window closes or the timeout expires (MEAS→STORE). STORE writes the result, the compare flag and the timeout flag, then returns to PICK (STORE→PICK). FINISH raises the done flag and clears the start bit (FINISH→IDLE).

Top module: `capscan_seq`

Register word addresses (`reg_addr`):

- 0, control: select [6:0], direction [13:7], scan mode [14], compare enable [15], interrupt enable [16], timeout interrupt enable [17], start [31].
- 1, configuration: window exponent [3:0], scan mask [14:8].
- 2, single result [15:0].
- 3, flags: done [0], timeout [14:8], compare [22:16].
- 4 to 7, result words.
- 8 to 11, threshold words.

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Writing 1 to control bit 31 starts an operation; hardware clears that bit and sets the done flag (flags bit 0) when the operation finishes.
- R3: In scan mode each channel n with mask bit n set is measured and its count is stored in result word 4+n/2, bits [15:0] for even n and [31:16] for odd n; the slots of unmasked channels and the single-result register keep their values.
- R4: In single mode only the channel given by the lowest set bit of the select field is measured; its count goes to the single-result register (address 2) and no per-channel slot changes.
- R5: The measurement window spans 2^(exponent+1) synchronized reference rising edges; the count is the number of synchronized oscillator rising edges in the window and saturates at 0xFFFF.
- R6: With compare enabled, after channel n is measured flag bit 16+n is set when direction bit n is 0 and the result is greater than threshold n, or when direction bit n is 1 and the result is less than it; with compare disabled no compare flag is set.
- R7: A channel that shows no oscillator edge within TIMEOUT_CYC system clocks of its window start gets result 0 and timeout flag bit 8+n, and the scan continues with the next channel; a silent channel whose window ends first gets result 0 and no timeout flag.
- R8: An operation with nothing to visit (an empty scan mask) finishes at once and sets only the done flag.
- R9: Writing 1 to a flag bit clears that bit; flag bits written with 0 are unchanged.
- R10: `irq` is high when interrupt enable is set and either compare is disabled with the done flag set or compare is enabled with any compare flag set, or when timeout interrupt enable is set and any timeout flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Asynchronous reference clock that times the measurement window |
| osc_in | input | 7 | Asynchronous oscillator signal of each touch channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check four things on every cycle. The start bit always drops together with the done flag rising. A saturated count never wraps. A timed-out channel is stored with a zero count, and a single-mode store leaves every per-channel slot untouched. Each visit through PICK retires exactly one pending channel, and the compare and done flags never move when they should not. The correctness of the counts against the window length, the per-channel packing, the compare direction and the interrupt gating is only visible in the bench scenarios. These scenarios use random masks, selects, thresholds and directions, with silent channels and empty masks as directed cases.

// File: rtl/capscan_pkg.sv
package capscan_pkg;

    localparam int NCH    = 7;
    localparam int CNT_W  = 16;
    localparam int CYC_W  = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int NWORD  = (NCH + 1) / 2;
    localparam int NSLOT  = 2 * NWORD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_MEAS,
        ST_STORE,
        ST_FINISH
    } scan_state_e;

    // index of the lowest set bit (0 when none is set)
    function automatic logic [CH_W-1:0] first_set(input logic [NCH-1:0] v);
        logic [CH_W-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) idx = CH_W'(i);
        end
        return idx;
    endfunction

    // lowest set bit isolated as a one-hot vector
    function automatic logic [NCH-1:0] first_onehot(input logic [NCH-1:0] v);
        return v & (~v + NCH'(1));
    endfunction

endpackage

// File: rtl/capscan_edge_sync.sv
module capscan_edge_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R5: a synchronized rising edge lasts exactly one system clock
    a_r5_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/capscan_meter.sv
module capscan_meter
    import capscan_pkg::*;
#(
    parameter int TIMEOUT_CYC = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             ref_rise,
    input  logic             osc_rise,
    input  logic [CYC_W-1:0] cyc,
    output logic [CNT_W-1:0] count,
    output logic             expired,
    output logic             window_end
);

    localparam int REF_W = (1 << CYC_W) + 1;
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LIMIT = TO_W'(TIMEOUT_CYC);

    logic [REF_W-1:0] ref_cnt_q;
    logic [REF_W-1:0] target;
    logic [TO_W-1:0]  idle_q;
    logic             seen_q;

    assign target = REF_W'(2) << cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            count     <= '0;
            idle_q    <= '0;
            seen_q    <= 1'b0;
        end else if (clear) begin
            ref_cnt_q <= '0;
            count     <= '0;
            idle_q    <= '0;
            seen_q    <= 1'b0;
        end else if (run) begin
            if (ref_rise) ref_cnt_q <= ref_cnt_q + REF_W'(1);
            if (osc_rise && count != '1) count <= count + CNT_W'(1);
            if (osc_rise) seen_q <= 1'b1;
            if (!seen_q && !osc_rise && idle_q < TO_LIMIT) idle_q <= idle_q + TO_W'(1);
        end
    end

    assign expired    = !seen_q && (idle_q >= TO_LIMIT);
    assign window_end = run && ((ref_cnt_q == target) || expired);

    // R5: a saturated count holds until the meter is cleared
    a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && !clear) |=> (count == '1));

endmodule

// File: rtl/capscan_fsm.sv
module capscan_fsm
    import capscan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            scan_mode,
    input  logic [NCH-1:0]  sel,
    input  logic [NCH-1:0]  mask,
    input  logic            window_end,
    output logic [CH_W-1:0] cur_ch,
    output logic            meas_clear,
    output logic            meas_run,
    output logic            store_en,
    output logic            finish_en,
    output logic            single_mode
);

    scan_state_e     state_q, state_d;
    logic [NCH-1:0]  pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PICK;
            ST_PICK:   state_d = (pend_q == '0) ? ST_FINISH : ST_MEAS;
            ST_MEAS:   if (window_end) state_d = ST_STORE;
            ST_STORE:  state_d = ST_PICK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // visit set and current channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= '0;
            cur_ch      <= '0;
            single_mode <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            pend_q      <= scan_mode ? mask : first_onehot(sel);
            single_mode <= !scan_mode;
        end else if (state_q == ST_PICK && pend_q != '0) begin
            cur_ch <= first_set(pend_q);
            pend_q <= pend_q & ~first_onehot(pend_q);
        end
    end

    // outputs
    always_comb begin
        meas_clear = (state_q == ST_PICK);
        meas_run   = (state_q == ST_MEAS);
        store_en   = (state_q == ST_STORE);
        finish_en  = (state_q == ST_FINISH);
    end

    // R3: every pass through PICK with work left retires exactly one channel
    a_r3_one_channel_per_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && pend_q != '0) |=>
            ($countones(pend_q) + 1 == $countones($past(pend_q))));

    // R8: an empty visit set goes straight to FINISH without measuring
    a_r8_empty_no_measure: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && pend_q == '0) |=> !meas_run);

endmodule

// File: rtl/capscan_seq.sv
module capscan_seq
    import capscan_pkg::*;
#(
    parameter int TIMEOUT_CYC = 65536
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_clk,
    input  logic [NCH-1:0] osc_in,
    input  logic           reg_wr,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           irq
);

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_CFG    = 4'd1;
    localparam logic [3:0] A_SINGLE = 4'd2;
    localparam logic [3:0] A_FLAG   = 4'd3;
    localparam int         A_RES0   = 4;
    localparam int         A_THR0   = A_RES0 + NWORD;

    // configuration
    logic [NCH-1:0]   sel_q, dir_q, mask_q;
    logic             scan_q, cmp_en_q, irq_en_q, to_en_q, start_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CNT_W-1:0] thr_q [NSLOT];

    // results and flags
    logic [CNT_W-1:0] res_q [NSLOT];
    logic [CNT_W-1:0] single_q;
    logic             done_f;
    logic [NCH-1:0]   to_f, cmp_f;

    // internal links
    logic [NCH-1:0]   osc_rise;
    logic             ref_rise;
    logic [CH_W-1:0]  cur_ch;
    logic             meas_clear, meas_run, store_en, finish_en, single_mode;
    logic [CNT_W-1:0] meter_cnt;
    logic             expired, window_end;
    logic [CNT_W-1:0] store_val;
    logic             cmp_pass;
    logic [NCH-1:0]   cur_hot;
    logic             wr_ctrl, wr_cfg, wr_flag;

    capscan_edge_sync #(.W(NCH)) u_osc_sync (
        .clk(clk), .rst_n(rst_n), .async_in(osc_in), .rise(osc_rise)
    );

    capscan_edge_sync #(.W(1)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_clk), .rise(ref_rise)
    );

    capscan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_q), .scan_mode(scan_q),
        .sel(sel_q), .mask(mask_q), .window_end(window_end), .cur_ch(cur_ch),
        .meas_clear(meas_clear), .meas_run(meas_run), .store_en(store_en),
        .finish_en(finish_en), .single_mode(single_mode)
    );

    capscan_meter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(meas_clear), .run(meas_run),
        .ref_rise(ref_rise), .osc_rise(osc_rise[cur_ch]), .cyc(cyc_q),
        .count(meter_cnt), .expired(expired), .window_end(window_end)
    );

    assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
    assign wr_cfg    = reg_wr && reg_addr == A_CFG;
    assign wr_flag   = reg_wr && reg_addr == A_FLAG;
    assign store_val = expired ? '0 : meter_cnt;
    assign cmp_pass  = dir_q[cur_ch] ? (store_val < thr_q[cur_ch]) : (store_val > thr_q[cur_ch]);
    assign cur_hot   = NCH'(1) << cur_ch;

    // control and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            dir_q    <= '0;
            scan_q   <= 1'b0;
            cmp_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            to_en_q  <= 1'b0;
            start_q  <= 1'b0;
            cyc_q    <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                sel_q    <= reg_wdata[6:0];
                dir_q    <= reg_wdata[13:7];
                scan_q   <= reg_wdata[14];
                cmp_en_q <= reg_wdata[15];
                irq_en_q <= reg_wdata[16];
                to_en_q  <= reg_wdata[17];
                start_q  <= reg_wdata[31];
            end
            if (finish_en) start_q <= 1'b0;
            if (wr_cfg) begin
                cyc_q  <= reg_wdata[3:0];
                mask_q <= reg_wdata[14:8];
            end
        end
    end

    // thresholds, one write port per packed word
    generate
        for (genvar k = 0; k < NWORD; k++) begin : g_thr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    thr_q[2*k]   <= '0;
                    thr_q[2*k+1] <= '0;
                end else if (reg_wr && reg_addr == 4'(A_THR0 + k)) begin
                    thr_q[2*k]   <= reg_wdata[15:0];
                    thr_q[2*k+1] <= reg_wdata[31:16];
                end
            end
        end
    endgenerate

    // result storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) res_q[i] <= '0;
            single_q <= '0;
        end else if (store_en) begin
            if (single_mode) single_q <= store_val;
            else             res_q[cur_ch] <= store_val;
        end
    end

    // sticky flags, write one to clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_f <= 1'b0;
            to_f   <= '0;
            cmp_f  <= '0;
        end else begin
            done_f <= (done_f & ~(wr_flag & reg_wdata[0])) | finish_en;
            to_f   <= (to_f & ~(wr_flag ? reg_wdata[14:8] : '0))
                    | ((store_en && expired) ? cur_hot : '0);
            cmp_f  <= (cmp_f & ~(wr_flag ? reg_wdata[22:16] : '0))
                    | ((store_en && cmp_en_q && cmp_pass) ? cur_hot : '0);
        end
    end

    assign irq = (irq_en_q && (cmp_en_q ? (|cmp_f) : done_f)) || (to_en_q && (|to_f));

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)
            reg_rdata = {start_q, 13'b0, to_en_q, irq_en_q, cmp_en_q, scan_q, dir_q, sel_q};
        else if (reg_addr == A_CFG)
            reg_rdata = {17'b0, mask_q, 4'b0, cyc_q};
        else if (reg_addr == A_SINGLE)
            reg_rdata = {16'b0, single_q};
        else if (reg_addr == A_FLAG)
            reg_rdata = {9'b0, cmp_f, 1'b0, to_f, 7'b0, done_f};
        for (int k = 0; k < NWORD; k++) begin
            if (reg_addr == 4'(A_RES0 + k)) reg_rdata = {res_q[2*k+1], res_q[2*k]};
            if (reg_addr == 4'(A_THR0 + k)) reg_rdata = {thr_q[2*k+1], thr_q[2*k]};
        end
    end

    // flattened view of the slots for checking
    logic [NSLOT*CNT_W-1:0] res_flat;
    always_comb begin
        for (int i = 0; i < NSLOT; i++) res_flat[i*CNT_W +: CNT_W] = res_q[i];
    end

    // R2: finishing clears the start bit and raises the done flag
    a_r2_start_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        finish_en |=> (!start_q && done_f));

    // R4: a single-mode store touches no per-channel slot
    a_r4_single_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && single_mode) |=> $stable(res_flat));

    // R7: a timed-out channel carries a zero count out of the meter
    a_r7_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && expired) |-> (meter_cnt == '0));

    // R9: writing one to the done bit clears it unless an operation finishes
    a_r9_done_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && reg_wdata[0] && !finish_en) |=> !done_f);

    // R6: compare flags only rise while compare is enabled
    a_r6_no_cmp_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_q && !wr_flag) |=> $stable(cmp_f));

endmodule

// File: tb/sim_capscan_seq.sv
module sim_capscan_seq;

    localparam int NC      = 7;
    localparam int REF_HP  = 8;     // reference half period in system clocks
    localparam int TO_CYC  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic [6:0]  osc_in = '0;
    logic [6:0]  osc_on = '1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int osc_cnt [NC];

    capscan_seq #(.TIMEOUT_CYC(TO_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .osc_in(osc_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    initial forever #(REF_HP * 10) ref_clk = ~ref_clk;

    // channel n toggles every n+2 clocks: period 2*(n+2)
    initial begin
        for (int n = 0; n < NC; n++) osc_cnt[n] = 0;
        forever begin
            @(negedge clk);
            for (int n = 0; n < NC; n++) begin
                osc_cnt[n]++;
                if (osc_cnt[n] >= n + 2) begin
                    osc_cnt[n] = 0;
                    if (osc_on[n]) osc_in[n] = ~osc_in[n];
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_op(input logic [31:0] ctrl);
        logic [31:0] d;
        wr(4'd0, ctrl | 32'h8000_0000);
        d = 32'h8000_0000;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd0, d);
            if (!d[31]) break;
        end
        check(!d[31], "R2 start bit self-clear", int'(d[31]), 0);
    endtask

    function automatic int per(input int ch);
        return 2 * (ch + 2);
    endfunction

    function automatic int cnt_lo(input int ch, input int cyc);
        int n = 2 << cyc;
        return ((n - 1) * 2 * REF_HP - 8) / per(ch) - 1;
    endfunction

    function automatic int cnt_hi(input int ch, input int cyc);
        int n = 2 << cyc;
        return (n * 2 * REF_HP + 24) / per(ch) + 1;
    endfunction

    function automatic logic [15:0] slot(input logic [31:0] w [4], input int ch);
        return (ch % 2) ? w[ch/2][31:16] : w[ch/2][15:0];
    endfunction

    function automatic int low_idx(input logic [6:0] v);
        for (int i = 0; i < NC; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic snap(output logic [31:0] w [4], output logic [31:0] s);
        for (int k = 0; k < 4; k++) rd(4'(4 + k), w[k]);
        rd(4'd2, s);
    endtask

    task automatic trial(input bit scan);
        logic [6:0]  mask, sel, dir, visit, cmp_exp;
        logic [15:0] thr [8];
        logic [31:0] w_old [4], w_new [4], s_old, s_new, fl;
        int cyc, lo, hi, ch;
        bit cmp_en, hi_thr, exp_irq;
        cyc    = 2 + int'($urandom % 2);
        mask   = 7'($urandom);
        sel    = 7'($urandom % 127 + 1);
        dir    = 7'($urandom);
        cmp_en = 1'($urandom);
        visit  = scan ? mask : (7'd1 << low_idx(sel));
        cmp_exp = '0;
        thr[7] = '0;
        for (int n = 0; n < NC; n++) begin
            lo = cnt_lo(n, cyc); hi = cnt_hi(n, cyc);
            hi_thr = 1'($urandom);
            thr[n] = hi_thr ? 16'(hi * 2 + 4) : 16'(lo / 2);
            if (visit[n] && cmp_en && (dir[n] ? hi_thr : !hi_thr)) cmp_exp[n] = 1'b1;
        end
        for (int k = 0; k < 4; k++) wr(4'(8 + k), {thr[2*k+1], thr[2*k]});
        wr(4'd3, 32'hFFFF_FFFF);
        snap(w_old, s_old);
        wr(4'd1, {17'b0, mask, 4'b0, 4'(cyc)});
        run_op({14'b0, 1'b1, 1'b1, cmp_en, scan, dir, sel});
        snap(w_new, s_new);
        for (int n = 0; n < NC; n++) begin
            lo = cnt_lo(n, cyc); hi = cnt_hi(n, cyc);
            if (scan && visit[n])
                check(int'(slot(w_new, n)) >= lo && int'(slot(w_new, n)) <= hi,
                      "R3/R5 scan slot count", int'(slot(w_new, n)), lo);
            else
                check(slot(w_new, n) == slot(w_old, n), scan ? "R3 unmasked slot kept" : "R4 slot kept",
                      int'(slot(w_new, n)), int'(slot(w_old, n)));
        end
        if (scan) begin
            check(s_new == s_old, "R3 single result kept", int'(s_new), int'(s_old));
        end else begin
            ch = low_idx(sel);
            lo = cnt_lo(ch, cyc); hi = cnt_hi(ch, cyc);
            check(int'(s_new) >= lo && int'(s_new) <= hi, "R4/R5 single count", int'(s_new), lo);
        end
        rd(4'd3, fl);
        check(fl == ({9'b0, cmp_exp, 16'b0} | 32'd1), "R6 flags after operation",
              int'(fl), int'({9'b0, cmp_exp, 16'b0} | 32'd1));
        exp_irq = cmp_en ? (cmp_exp != '0) : 1'b1;
        check(irq == exp_irq, "R10 irq after operation", int'(irq), int'(exp_irq));
    endtask

    initial begin
        logic [31:0] d, w [4], s;
        int lo, hi;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), d);
            check(d == 32'd0, "R1 register after reset", int'(d), 0);
        end
        check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

        // R8: empty scan mask, compare off, interrupt on
        wr(4'd1, 32'd2);
        run_op(32'h0001_4000);
        rd(4'd3, d);
        check(d == 32'd1, "R8 only done flag", int'(d), 1);
        check(irq == 1'b1, "R10 irq on done", int'(irq), 1);
        wr(4'd3, 32'd1);
        rd(4'd3, d);
        check(d == 32'd0, "R9 done cleared by W1C", int'(d), 0);
        check(irq == 1'b0, "R10 irq low after clear", int'(irq), 0);

        // random scan and single operations
        for (int t = 0; t < 10; t++) trial(1'b1);
        for (int t = 0; t < 6; t++) trial(1'b0);

        // R7: channel 3 silent with a window longer than the timeout
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd10, 32'h0000_0000);
        osc_on[3] = 1'b0;
        wr(4'd1, {17'b0, 7'b010_1000, 4'b0, 4'd5});
        run_op(32'h0000_4000);
        snap(w, s);
        check(w[1][31:16] == 16'd0, "R7 timed-out slot zero", int'(w[1][31:16]), 0);
        lo = cnt_lo(5, 5); hi = cnt_hi(5, 5);
        check(int'(w[2][31:16]) >= lo && int'(w[2][31:16]) <= hi,
              "R7 scan continues after timeout", int'(w[2][31:16]), lo);
        rd(4'd3, d);
        check(d == 32'h0000_0801, "R7 timeout flag", int'(d), 32'h801);
        check(irq == 1'b0, "R10 irq gated off", int'(irq), 0);
        wr(4'd0, 32'h0002_4000);
        check(irq == 1'b1, "R10 timeout irq enable", int'(irq), 1);
        wr(4'd3, 32'h0000_0800);
        rd(4'd3, d);
        check(d == 32'd1, "R9 only timeout bit cleared", int'(d), 1);
        check(irq == 1'b0, "R10 irq after timeout clear", int'(irq), 0);

        // R7: silent channel 2 with a short window, single mode, no timeout
        osc_on[2] = 1'b0;
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd1, 32'd2);
        run_op(32'h0000_0004);
        rd(4'd2, d);
        check(d == 32'd0, "R7 silent short window result", int'(d), 0);
        rd(4'd3, d);
        check(d == 32'd1, "R7 no timeout flag in short window", int'(d), 1);
        osc_on = '1;

        // R6: compare disabled leaves compare flags clear even with low thresholds
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd1, {17'b0, 7'b111_1111, 4'b0, 4'd2});
        run_op(32'h0001_4000);
        rd(4'd3, d);
        check(d == 32'd1, "R6 compare off sets no compare flag", int'(d), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule